// File: doc/BRIEF.md
# IrDA SIR Pulse Encoder

This block turns a UART-format serial stream into the short infrared pulses used at serial-infrared rates. A separate baud generator supplies `bitclk_en`, a one-cycle strobe that fires sixteen times per bit period. The encoder waits for the falling edge of a start bit, which it re-anchors its own timing to, and then frames ten bits (start, eight data, stop). Each bit is sixteen strobes long.

A zero bit gives one three-strobe high pulse that starts after seven low strobes. A one bit leaves the output low for the whole bit. The serial input passes through a two-flop synchronizer before edge detection. Once a frame is running, further edges on the input cannot shift the bit grid. The encoder returns to idle after the stop bit and waits for the next high-to-low transition.

Top module: `irda_sir_encoder`

## Requirements
- R1: Bit timing advances only on cycles where `bitclk_en` is 1. A bit lasts exactly 16 strobes, however many clock cycles separate the strobes.
- R2: For a bit whose value is 0, `txir` is 1 after strobes 16b+7, 16b+8 and 16b+9 of the frame (b = bit index 0..9), and 0 after every other strobe of that bit.
- R3: For a bit whose value is 1, `txir` stays 0 for all 16 strobes of that bit.
- R4: Bit 0 (start) is always encoded as a zero. Bit 9 (stop) is always encoded as a one, even if `tx` is low during it. Bits 1..8 take the level of `tx` sampled inside the bit, in arrival order.
- R5: A high-to-low change of `tx` seen while idle anchors a frame on the third rising clock edge after the change. Strobes are counted from the following edges. `txir` stays 0 until the seventh strobe.
- R6: After 160 strobes the encoder is idle with `txir` at 0. Falling edges of `tx` inside a frame do not re-anchor it.
- R7: Only a high-to-low transition re-arms a frame. A `tx` held low while idle starts no frame.
- R8: When `enable` is 0 at a rising edge, `txir` is 0 after that edge and the running frame is abandoned.
- R9: Synchronous active-low reset drives `txir` to 0 and abandons any frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable; 0 forces the output low and clears the counters |
| bitclk_en | input | 1 | Bit-clock strobe, 16 per bit period |
| tx | input | 1 | UART-format serial input, idle high |
| txir | output | 1 | Infrared pulse output, active high |

## Verification
A `tx` change takes three rising edges to reach the frame anchor: two synchronizer stages and one edge-detect register. After that, `txir` is a register that changes on the same edge as the strobe that moves the slot counter. The bench therefore drives `tx` and `bitclk_en` on falling edges and counts the strobes the design has taken since the anchor edge. At each following falling edge it compares `txir` with the value that strobe count predicts. Strobe spacing varies at random between two and six idle cycles. This shows that pulse placement follows strobes and not clock cycles. The enable and reset checks are sampled at the falling edge right after the edge where they take effect.

// File: rtl/irda_enc_pkg.sv
// Package: shared types for the serial-infrared encoder.
package irda_enc_pkg;
    typedef enum logic {
        ENC_IDLE  = 1'b0,
        ENC_FRAME = 1'b1
    } enc_state_t;
endpackage

// File: rtl/irda_enc_sync.sv
// Module: irda_enc_sync
// Multi-stage synchronizer for the asynchronous serial input.
// Assumes the line idles high, so every stage resets to 1.
module irda_enc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_sync
);
    logic [STAGES-1:0] chain;

    // Shift the raw input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_in};
    end

    assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/irda_enc_edge.sv
// Module: irda_enc_edge
// Detects a high-to-low change on the synchronized line.
// The history flop runs even while disabled, so a line held low
// across a disable does not look like a new start edge.
module irda_enc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic line,
    output logic fall
);
    logic line_q;

    // Keep the previous line level.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b1;
        else        line_q <= line;
    end

    assign fall = enable && line_q && !line;
endmodule

// File: rtl/irda_enc_timer.sv
// Module: irda_enc_timer
// Frame sequencer: counts strobes within a bit and bits within a frame.
// It flags the strobes that open and close the pulse window.
// Assumes start is asserted only when a frame may begin.
module irda_enc_timer
    import irda_enc_pkg::*;
#(
    parameter int SLOTS       = 16,
    parameter int FRAME_BITS  = 10,
    parameter int PULSE_START = 7,
    parameter int PULSE_LEN   = 3,
    localparam int SW = $clog2(SLOTS),
    localparam int BW = $clog2(FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          bitclk_en,
    input  logic          start,
    output logic          busy,
    output logic [SW-1:0] slot,
    output logic [BW-1:0] bit_idx,
    output logic          pulse_set,
    output logic          pulse_clr
);
    localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);
    localparam logic [BW-1:0] LAST_BIT  = BW'(FRAME_BITS - 1);
    localparam logic [SW-1:0] SET_SLOT  = SW'(PULSE_START - 1);
    localparam logic [SW-1:0] CLR_SLOT  = SW'(PULSE_START + PULSE_LEN - 1);

    enc_state_t state;

    // Frame state, slot counter and bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state   <= ENC_IDLE;
            slot    <= '0;
            bit_idx <= '0;
        end else begin
            case (state)
                ENC_IDLE: begin
                    if (start) begin
                        state   <= ENC_FRAME;
                        slot    <= '0;
                        bit_idx <= '0;
                    end
                end
                default: begin
                    if (bitclk_en) begin
                        if (slot == LAST_SLOT) begin
                            slot <= '0;
                            if (bit_idx == LAST_BIT) begin
                                state   <= ENC_IDLE;
                                bit_idx <= '0;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end else begin
                            slot <= slot + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign busy      = (state == ENC_FRAME);
    assign pulse_set = busy && bitclk_en && (slot == SET_SLOT);
    assign pulse_clr = busy && bitclk_en && (slot == CLR_SLOT);
endmodule

// File: rtl/irda_enc_shaper.sv
// Module: irda_enc_shaper
// Drives the pulse output. The start bit is forced to zero and the
// stop bit to one; data bits use the synchronized line level.
module irda_enc_shaper #(
    parameter int FRAME_BITS = 10,
    localparam int BW = $clog2(FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          line,
    input  logic [BW-1:0] bit_idx,
    input  logic          pulse_set,
    input  logic          pulse_clr,
    output logic          txir
);
    localparam logic [BW-1:0] STOP_BIT = BW'(FRAME_BITS - 1);

    logic bit_is_zero;

    // Decide whether the current bit carries a pulse.
    always_comb begin
        if (bit_idx == '0)            bit_is_zero = 1'b1;
        else if (bit_idx == STOP_BIT) bit_is_zero = 1'b0;
        else                          bit_is_zero = !line;
    end

    // Open and close the pulse window.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)            txir <= 1'b0;
        else if (pulse_set && bit_is_zero) txir <= 1'b1;
        else if (pulse_clr)               txir <= 1'b0;
    end
endmodule

// File: rtl/irda_sir_encoder.sv
// Module: irda_sir_encoder
// Top level: UART-format serial input to infrared pulse output.
// Assumes bitclk_en is a single-cycle strobe, 16 per bit period.
module irda_sir_encoder #(
    parameter int SYNC_STAGES = 2,
    parameter int SLOTS       = 16,
    parameter int FRAME_BITS  = 10,
    parameter int PULSE_START = 7,
    parameter int PULSE_LEN   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic bitclk_en,
    input  logic tx,
    output logic txir
);
    localparam int SW = $clog2(SLOTS);
    localparam int BW = $clog2(FRAME_BITS);

    logic          line;
    logic          fall;
    logic          busy;
    logic [SW-1:0] slot;
    logic [BW-1:0] bit_idx;
    logic          pulse_set;
    logic          pulse_clr;

    irda_enc_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .d_in(tx), .d_sync(line)
    );

    irda_enc_edge edge_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .line(line), .fall(fall)
    );

    irda_enc_timer #(
        .SLOTS(SLOTS), .FRAME_BITS(FRAME_BITS),
        .PULSE_START(PULSE_START), .PULSE_LEN(PULSE_LEN)
    ) timer_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .bitclk_en(bitclk_en),
        .start(fall && !busy), .busy(busy), .slot(slot), .bit_idx(bit_idx),
        .pulse_set(pulse_set), .pulse_clr(pulse_clr)
    );

    irda_enc_shaper #(.FRAME_BITS(FRAME_BITS)) shaper_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .line(line),
        .bit_idx(bit_idx), .pulse_set(pulse_set), .pulse_clr(pulse_clr),
        .txir(txir)
    );
endmodule

// File: rtl/irda_enc_chk.sv
// Module: irda_enc_chk
// Property checker bound to irda_sir_encoder.
module irda_enc_chk #(
    parameter int SLOTS       = 16,
    parameter int FRAME_BITS  = 10,
    parameter int PULSE_START = 7,
    parameter int PULSE_LEN   = 3,
    localparam int SW = $clog2(SLOTS),
    localparam int BW = $clog2(FRAME_BITS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic          bitclk_en,
    input logic          txir,
    input logic          busy,
    input logic [SW-1:0] slot,
    input logic [BW-1:0] bit_idx
);
    logic [SW:0] hi_ticks;

    // Count strobes seen while the output is high.
    always_ff @(posedge clk) begin
        if (!rst_n || !txir) hi_ticks <= '0;
        else if (bitclk_en)  hi_ticks <= hi_ticks + 1'b1;
    end

    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        txir |-> (hi_ticks < (SW+1)'(PULSE_LEN)));                            // R2
    AST_PULSE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        txir |-> (busy && slot >= SW'(PULSE_START)
                  && slot < SW'(PULSE_START + PULSE_LEN)));                    // R2
    AST_RISE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txir) |-> $past(bitclk_en));                                     // R1
    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bit_idx == BW'(FRAME_BITS - 1)) |-> !txir);                    // R4
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !txir);                                                      // R6
    AST_DISABLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !txir);                                                    // R8
endmodule

bind irda_sir_encoder irda_enc_chk #(
    .SLOTS(SLOTS), .FRAME_BITS(FRAME_BITS),
    .PULSE_START(PULSE_START), .PULSE_LEN(PULSE_LEN)
) chk_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .bitclk_en(bitclk_en),
    .txir(txir), .busy(busy), .slot(slot), .bit_idx(bit_idx)
);

// File: tb/irda_sir_encoder_tb.sv
// Bench: random bytes and strobe spacing plus directed corner cases.
module irda_sir_encoder_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic bitclk_en = 1'b0;
    logic tx = 1'b1;
    logic txir;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irda_sir_encoder dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .bitclk_en(bitclk_en), .tx(tx), .txir(txir)
    );

    // Expected output after t strobes of a frame with encoded bits enc.
    function automatic logic exp_txir(int t, logic [9:0] enc);
        int b = t / 16;
        int s = t % 16;
        if (b >= 10) return 1'b0;
        return (enc[b] == 1'b0) && (s >= 7) && (s < 10);
    endfunction

    function automatic string req_of(int t, logic [9:0] enc);
        int b = t / 16;
        if (b >= 10)      return "R6";
        if (b == 0)       return "R5";
        if (b == 9)       return "R4";
        if (enc[b] == 0)  return "R2";
        return "R3";
    endfunction

    task automatic check(logic act, logic exp, string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: txir=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: drive at the falling edge, return at the next one.
    task automatic step(logic bce, logic txv);
        bitclk_en = bce;
        tx = txv;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Frame: abort_kind 0 none, 1 enable drop, 2 reset, at abort_at strobes.
    task automatic run_frame(logic [7:0] d, bit stop_low, int max_gap,
                             int abort_kind, int abort_at);
        logic [9:0] enc;
        logic [9:0] drv;
        int ticks = 0;
        int gap = 0;
        enc = {1'b1, d, 1'b0};
        drv = {!stop_low, d, 1'b0};
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 1'b1);
            check(txir, 1'b0, "R6");
        end
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 1'b0);
            check(txir, 1'b0, "R5");
        end
        while (ticks < 160) begin
            logic bce;
            bce = (gap >= max_gap) || ((gap >= 2) && ($urandom % 2 == 1));
            step(bce, drv[ticks / 16]);
            if (bce) begin
                ticks++;
                gap = 0;
            end else begin
                gap++;
            end
            check(txir, exp_txir(ticks, enc), req_of(ticks, enc));
            if (abort_kind != 0 && ticks == abort_at) begin
                if (abort_kind == 1) begin
                    enable = 1'b0;
                    step(1'b0, tx);
                    check(txir, 1'b0, "R8");
                    enable = 1'b1;
                end else begin
                    rst_n = 1'b0;
                    step(1'b0, 1'b1);
                    check(txir, 1'b0, "R9");
                    rst_n = 1'b1;
                end
                return;
            end
        end
        for (int i = 0; i < 6; i++) begin
            step(i % 2 == 0, drv[9]);
            check(txir, 1'b0, "R6");
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            step(1'b1, 1'b1);
            check(txir, 1'b0, "R9");
        end
        rst_n = 1'b1;
        enable = 1'b1;
        // R2/R3 directed patterns, fast and slow strobes (R1)
        run_frame(8'h00, 1'b0, 2, 0, 0);
        run_frame(8'hFF, 1'b0, 6, 0, 0);
        run_frame(8'h55, 1'b0, 3, 0, 0);
        run_frame(8'hA3, 1'b0, 5, 0, 0);
        // R4: stop bit held low still encodes as one
        run_frame(8'h0F, 1'b1, 3, 0, 0);
        // R8: enable dropped during the start pulse
        run_frame(8'h00, 1'b0, 3, 1, 8);
        // R7: tx stays low, no frame may start
        for (int i = 0; i < 120; i++) begin
            step(i % 3 == 0, 1'b0);
            check(txir, 1'b0, "R7");
        end
        // R9: reset in the middle of a data pulse
        run_frame(8'h00, 1'b0, 3, 2, 40);
        // Random traffic
        for (int n = 0; n < 24; n++) begin
            run_frame(8'($urandom), ($urandom % 4 == 0), 2 + int'($urandom % 5), 0, 0);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule